// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 interrupt lines, each governed by its own control word, and raises a single request toward the processor whenever at least one line is eligible to interrupt. Every line can be set to react to a falling edge, a low level, a rising edge or a high level. Every line also carries an enable, a request flag and a three-bit urgency level, where 0 is the most urgent and 7 switches the line off. A global threshold lets through only levels strictly below its value. Among the eligible lines, the controller picks the one with the most urgent level. When levels tie, the lowest line number wins.

Software reaches the block through a plain 32-bit register port with a single-cycle write strobe and a read strobe. Read data comes back on the clock edge after the strobe and holds until the next read. The status word at byte address 0x000 reports the current winner. The threshold lives at 0x004. The control word of line n lives at 0x100 + 4·n. Raw inputs are asynchronous and pass through two flip-flops before any detection is done.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every control word reads 0x00000007 (disabled, no request, falling-edge mode, level 7), the threshold reads 0, the status word reads 0 and `irq_out` is low.
- R2: A control word keeps the enable in bit 12, the request flag in bit 8, the sense mode in bits 5:4 and the level in bits 2:0, and all other bits read as 0. The threshold word keeps its value in bits 18:16 and all other bits read as 0.
- R3: A raw input change held stable reaches the request flag through two synchronizing flops. In a level mode, `irq_out` has not yet changed after the second rising edge and has changed after the third.
- R4: Sense mode 10 latches the flag on a rising input and mode 00 latches it on a falling input; the opposite transition is ignored. A latched flag stays set after the input returns. Writing 0 to bit 8 clears it, and writing 1 leaves it set.
- R5: Sense mode 11 makes the flag follow a high input and mode 01 makes it follow a low input. Writing 0 to bit 8 has no effect while the input is active.
- R6: A line with its enable at 0 never drives `irq_out`, although its request flag still reads back as set.
- R7: With threshold n, only levels 0 to n-1 are eligible. Threshold 0 blocks every line.
- R8: A line at level 7 never makes `irq_out` high, whatever the threshold.
- R9: Among eligible lines the lowest level number wins. On equal levels the lowest line number wins.
- R10: A status read returns the winning line number in bits 27:22 and its level in bits 18:16, and returns 0 when no line is eligible. Read data appears on the edge after `reg_rd`.
- R11: `irq_out` is high exactly when at least one line is enabled, has its flag set, and has a level below both 7 and the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Raw asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A corrupted request flag shows up at the ports in one of two ways. A flag that latches the wrong transition or fails to hold is visible on `irq_out` within three cycles of the input change, and on the next read of the line's control word. A broken comparison or ordering in the selection logic shows up immediately, as a wrong line or level in the very next status read. A wrong threshold shows up as `irq_out` staying high or low across the boundary level. A synchronizer that is one flop short or one flop long moves the `irq_out` edge by exactly one cycle against the three-edge window.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic [1:0] {
    SENSE_FALL = 2'b00,
    SENSE_LOW  = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_HIGH = 2'b11
  } sense_e;

  localparam int EN_BIT   = 12;
  localparam int REQ_BIT  = 8;
  localparam int MODE_LO  = 4;
  localparam int LVL_LO   = 0;
  localparam int THR_LO   = 16;
  localparam int STS_SRC  = 22;
  localparam int STS_LVL  = 16;
  localparam logic [2:0] LVL_OFF = 3'd7;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_source.sv
module irq_source
  import icu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s,
  input  logic       wr,
  input  logic       w_en,
  input  logic       w_req,
  input  logic [1:0] w_mode,
  input  logic [2:0] w_lvl,
  output logic       en,
  output logic       req,
  output sense_e     mode,
  output logic [2:0] lvl
);
  logic   s_prev;
  logic   hit;
  logic   req_n;
  sense_e mode_n;

  assign mode_n = wr ? sense_e'(w_mode) : mode;

  always_comb begin
    unique case (mode_n)
      SENSE_FALL: hit = s_prev & ~s;
      SENSE_RISE: hit = ~s_prev & s;
      SENSE_LOW:  hit = ~s;
      default:    hit = s;
    endcase
  end

  // level modes (bit 0 set) follow the line; edge modes latch until cleared
  assign req_n = mode_n[0] ? hit : (hit | (req & ~(wr & ~w_req)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev <= 1'b0;
      req    <= 1'b0;
      en     <= 1'b0;
      mode   <= SENSE_FALL;
      lvl    <= LVL_OFF;
    end else begin
      s_prev <= s;
      req    <= req_n;
      if (wr) begin
        en   <= w_en;
        mode <= mode_n;
        lvl  <= w_lvl;
      end
    end
  end

  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && req && !wr) |=> req);

  assert_level_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_HIGH && s && !wr) |=> req);

  assert_level_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LOW && !s && !wr) |=> req);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC  = 64,
  parameter int IDX_W = 6
) (
  input  logic [NSRC-1:0]      elig,
  input  logic [NSRC-1:0][2:0] lvl,
  output logic                 found,
  output logic [IDX_W-1:0]     win_idx,
  output logic [2:0]           win_lvl
);
  // strict compare keeps the earlier (lower-numbered) line on equal levels
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = 3'd7;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || (lvl[i] < win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import icu_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int ADDR_W = $clog2(NSRC) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int SLOTS = 2 ** IDX_W;

  logic [NSRC-1:0]      s_sync;
  logic [NSRC-1:0]      en_a;
  logic [NSRC-1:0]      req_a;
  logic [NSRC-1:0][2:0] lvl_a;
  logic [NSRC-1:0][1:0] mode_a;
  logic [NSRC-1:0]      elig;
  logic [NSRC-1:0]      wr_a;
  logic [31:0]          ctrl_w [SLOTS];
  logic [2:0]           thr_q;
  logic                 found;
  logic [IDX_W-1:0]     win_idx;
  logic [2:0]           win_lvl;
  logic [31:0]          rd_mux;

  logic                 in_src;
  logic [IDX_W-1:0]     sel;
  logic                 sel_sts;
  logic                 sel_thr;

  assign in_src  = reg_addr[ADDR_W-1];
  assign sel     = reg_addr[IDX_W+1:2];
  assign sel_sts = !in_src && (sel == IDX_W'(0));
  assign sel_thr = !in_src && (sel == IDX_W'(1));

  logic unused_bits;
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:19], reg_wdata[15:13],
                         reg_wdata[11:9], reg_wdata[7:6], reg_wdata[3]};

  irq_sync #(.W(NSRC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (irq_in),
    .q    (s_sync)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    sense_e m;

    assign wr_a[g] = reg_wr && in_src && (sel == IDX_W'(g));

    irq_source u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .s     (s_sync[g]),
      .wr    (wr_a[g]),
      .w_en  (reg_wdata[EN_BIT]),
      .w_req (reg_wdata[REQ_BIT]),
      .w_mode(reg_wdata[MODE_LO+:2]),
      .w_lvl (reg_wdata[LVL_LO+:3]),
      .en    (en_a[g]),
      .req   (req_a[g]),
      .mode  (m),
      .lvl   (lvl_a[g])
    );

    assign mode_a[g] = m;
    assign elig[g]   = en_a[g] && req_a[g] && (lvl_a[g] != LVL_OFF) && (lvl_a[g] < thr_q);
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_rd
    if (k < NSRC) begin : g_live
      always_comb begin
        ctrl_w[k]              = '0;
        ctrl_w[k][EN_BIT]      = en_a[k];
        ctrl_w[k][REQ_BIT]     = req_a[k];
        ctrl_w[k][MODE_LO+:2]  = mode_a[k];
        ctrl_w[k][LVL_LO+:3]   = lvl_a[k];
      end
    end else begin : g_hole
      assign ctrl_w[k] = '0;
    end
  end

  irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .elig   (elig),
    .lvl    (lvl_a),
    .found  (found),
    .win_idx(win_idx),
    .win_lvl(win_lvl)
  );

  assign irq_out = found;

  always_comb begin
    rd_mux = '0;
    if (in_src) begin
      rd_mux = ctrl_w[sel];
    end else if (sel_sts) begin
      if (found) begin
        rd_mux[STS_SRC+:6] = 6'(win_idx);
        rd_mux[STS_LVL+:3] = win_lvl;
      end
    end else if (sel_thr) begin
      rd_mux[THR_LO+:3] = thr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && sel_thr) thr_q <= reg_wdata[THR_LO+:3];
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assert_threshold_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_lvl < thr_q));

  assert_level_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_lvl != LVL_OFF));

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (en_a[win_idx] && req_a[win_idx]));

  assert_winner_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (lvl_a[win_idx] == win_lvl));

  assert_idle_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel_sts && !irq_out) |=> (reg_rdata == 32'd0));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NSRC = 64;
  localparam int AW   = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_in = '0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [2:0] thr;
    logic [5:0] a;
    logic [2:0] la;
    logic [5:0] b;
    logic [2:0] lb;
    logic       irq;
    logic [5:0] src;
    logic [2:0] lvl;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd7, 6'd5,  3'd3, 6'd9,  3'd1, 1'b1, 6'd9,  3'd1},
    '{3'd7, 6'd5,  3'd2, 6'd9,  3'd2, 1'b1, 6'd5,  3'd2},
    '{3'd2, 6'd5,  3'd2, 6'd9,  3'd3, 1'b0, 6'd0,  3'd0},
    '{3'd3, 6'd5,  3'd2, 6'd9,  3'd3, 1'b1, 6'd5,  3'd2},
    '{3'd0, 6'd1,  3'd0, 6'd2,  3'd0, 1'b0, 6'd0,  3'd0},
    '{3'd7, 6'd3,  3'd7, 6'd4,  3'd7, 1'b0, 6'd0,  3'd0},
    '{3'd7, 6'd63, 3'd0, 6'd16, 3'd6, 1'b1, 6'd63, 3'd0},
    '{3'd1, 6'd40, 3'd0, 6'd0,  3'd0, 1'b1, 6'd0,  3'd0}
  };

  function automatic logic [AW-1:0] ctrl_a(input int n);
    return AW'(32'h100 + 4 * n);
  endfunction

  localparam logic [AW-1:0] STS_A = 9'h000;
  localparam logic [AW-1:0] THR_A = 9'h004;

  function automatic logic [31:0] sts(input logic [5:0] s, input logic [2:0] l);
    return (32'(s) << 22) | (32'(l) << 16);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq", 32'(irq_out), 0);
    rd(ctrl_a(0), v);  chk("R1 ctrl0", v, 32'h7);
    rd(ctrl_a(63), v); chk("R1 ctrl63", v, 32'h7);
    rd(THR_A, v);      chk("R1 thr", v, 0);
    rd(STS_A, v);      chk("R1 status", v, 0);

    // R2 field layout
    wr(ctrl_a(10), 32'hFFFF_FFFF);
    rd(ctrl_a(10), v); chk("R2 ctrl fields", v, 32'h0000_1037);
    wr(THR_A, 32'hFFFF_FFFF);
    rd(THR_A, v);      chk("R2 thr field", v, 32'h0007_0000);
    chk("R8 level7 enabled quiet", 32'(irq_out), 0);
    wr(ctrl_a(10), 32'h0000_0037);

    // R9 R7 R8 R10 R11 vector walk
    foreach (VEC[i]) begin
      irq_in = '0;
      irq_in[VEC[i].a] = 1'b1;
      irq_in[VEC[i].b] = 1'b1;
      wr(THR_A, 32'(VEC[i].thr) << 16);
      wr(ctrl_a(VEC[i].a), 32'h1030 | 32'(VEC[i].la));
      wr(ctrl_a(VEC[i].b), 32'h1030 | 32'(VEC[i].lb));
      idle(5);
      chk($sformatf("R11 vec%0d irq", i), 32'(irq_out), 32'(VEC[i].irq));
      rd(STS_A, v);
      chk($sformatf("R9 R10 vec%0d status", i), v,
          VEC[i].irq ? sts(VEC[i].src, VEC[i].lvl) : 32'd0);
      wr(ctrl_a(VEC[i].a), 32'h0037);
      wr(ctrl_a(VEC[i].b), 32'h0037);
      irq_in = '0;
      idle(5);
    end

    wr(THR_A, 32'h0007_0000);

    // R3 synchronizer latency
    wr(ctrl_a(20), 32'h1030);
    @(negedge clk); irq_in[20] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3 not before third edge", 32'(irq_out), 0);
    @(posedge clk); @(negedge clk);
    chk("R3 at third edge", 32'(irq_out), 1);
    irq_in[20] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3 release held", 32'(irq_out), 1);
    @(posedge clk); @(negedge clk);
    chk("R3 release third edge", 32'(irq_out), 0);
    wr(ctrl_a(20), 32'h0030);

    // R4 rising edge latch
    wr(ctrl_a(30), 32'h1021);
    @(negedge clk); irq_in[30] = 1'b1;
    idle(3); irq_in[30] = 1'b0;
    idle(5);
    chk("R4 rise latched irq", 32'(irq_out), 1);
    rd(ctrl_a(30), v); chk("R4 rise flag", v, 32'h1121);
    rd(STS_A, v);      chk("R10 status rise", v, sts(6'd30, 3'd1));
    wr(ctrl_a(30), 32'h1121);
    rd(ctrl_a(30), v); chk("R4 write one keeps", v, 32'h1121);
    wr(ctrl_a(30), 32'h1021);
    rd(ctrl_a(30), v); chk("R4 write zero clears", v, 32'h1021);
    chk("R4 cleared irq", 32'(irq_out), 0);
    // falling edge mode
    wr(ctrl_a(30), 32'h1001);
    @(negedge clk); irq_in[30] = 1'b1;
    idle(5);
    chk("R4 rise ignored in fall mode", 32'(irq_out), 0);
    irq_in[30] = 1'b0;
    idle(5);
    chk("R4 fall latched irq", 32'(irq_out), 1);
    rd(ctrl_a(30), v); chk("R4 fall flag", v, 32'h1101);
    wr(ctrl_a(30), 32'h1001);
    rd(ctrl_a(30), v); chk("R4 fall cleared", v, 32'h1001);
    wr(ctrl_a(30), 32'h0001);

    // R5 low-level mode
    wr(ctrl_a(31), 32'h1011);
    idle(5);
    chk("R5 low active irq", 32'(irq_out), 1);
    rd(ctrl_a(31), v); chk("R5 low flag", v, 32'h1111);
    wr(ctrl_a(31), 32'h1011);
    rd(ctrl_a(31), v); chk("R5 clear ignored", v, 32'h1111);
    chk("R5 irq after clear attempt", 32'(irq_out), 1);
    @(negedge clk); irq_in[31] = 1'b1;
    idle(5);
    chk("R5 inactive irq", 32'(irq_out), 0);
    rd(ctrl_a(31), v); chk("R5 flag follows", v, 32'h1011);
    wr(ctrl_a(31), 32'h0011);

    // R6 enable gate
    wr(ctrl_a(32), 32'h0030);
    @(negedge clk); irq_in[32] = 1'b1;
    idle(5);
    chk("R6 disabled quiet", 32'(irq_out), 0);
    rd(ctrl_a(32), v); chk("R6 flag visible", v, 32'h0130);
    wr(ctrl_a(32), 32'h1030);
    idle(2);
    chk("R6 enabled irq", 32'(irq_out), 1);
    rd(STS_A, v); chk("R10 status src32", v, sts(6'd32, 3'd0));
    wr(ctrl_a(32), 32'h0030);
    irq_in[32] = 1'b0;
    idle(5);

    // R7 threshold boundary
    wr(ctrl_a(40), 32'h1036);
    @(negedge clk); irq_in[40] = 1'b1;
    wr(THR_A, 32'h0006_0000);
    idle(5);
    chk("R7 level6 thr6 blocked", 32'(irq_out), 0);
    wr(THR_A, 32'h0007_0000);
    idle(2);
    chk("R7 level6 thr7 passes", 32'(irq_out), 1);
    wr(THR_A, 32'h0000_0000);
    idle(2);
    chk("R7 thr0 blocks", 32'(irq_out), 0);
    rd(STS_A, v); chk("R10 idle status", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule